// File: doc/BRIEF.md
# PHY Link Resolver and Port Override

The block watches the copper links of a small switch in hardware. On each sweep it visits the switch ports one after another, in ascending index order. For every port that is marked in use and is not held in a fixed configuration, it reads the attached PHY through an MDIO request/acknowledge interface. From the standard management registers it works out whether the link is up, and at what speed and duplex. When the link has changed since the last look, it writes two bytes into the switch for that port: an override byte and a traffic-control byte.

A stored link bit is kept for each port, and the port is touched only on a link edge. A periodic tick can therefore drive the sweep cheaply. A start pulse clears every stored bit, so a sweep launched by that pulse reports every link that is already up. Ports from a fixed index upward sit on the external management bus, and the request marks them as such.

Top module: `lres_link_monitor`

## Requirements
- R1: After a synchronous active-low reset, busy_o, mdio_req_o and sw_wr_o are low and every bit of link_state_o is 0.
- R2: A sweep starts only from idle, on start_i or tick_i, and visits ports in ascending index order. Either pulse that arrives while a sweep is running is ignored.
- R3: A port whose port_used_i bit is 0, or whose port_bypass_i bit is 1, gets no MDIO request and no switch write, and its link_state_o bit does not change.
- R4: The status register (address 1) is read twice back to back and only the second value counts. Link is status bit 2 and extended ability is status bit 8.
- R5: A second status value of 0xFFFF means no PHY: that port gets no write and keeps its link_state_o bit.
- R6: A port is written, and its link_state_o bit updated, only when status bit 2 differs from the stored bit. With no change, nothing is written.
- R7: On a link-down edge, override byte 0x40 is written (sw_sel_o=0), then traffic-control byte 0x03 (sw_sel_o=1) in the next cycle.
- R8: On a link-up edge, registers 4 (local ability) and 5 (partner ability) are read and ANDed. In the result, bit 5 is 10 half, bit 6 is 10 full, bit 7 is 100 half and bit 8 is 100 full. Speed is 100 if bit 7 or bit 8 survives, otherwise 10. Duplex is full for 100 full, or for 10 full when no 100 mode survives.
- R9: Only when status bit 8 is set are register 9 (local gigabit: bit 9 full, bit 8 half) and register 10 (partner gigabit: bit 11 full, bit 10 half) also read. If both sides show a gigabit mode, speed is 1000 and duplex is full exactly when register 10 bit 11 is set.
- R10: The link-up override byte has bit 6 (enable) and bit 0 (link) set. It adds bit 3 for 1000, bit 2 for 100 and bit 1 for full duplex, and leaves bits 7, 5 and 4 at 0. The next cycle writes traffic-control byte 0x00.
- R11: mdio_ext_o is 1 for requests on behalf of ports with index EXT_FIRST (4) or higher and 0 for lower ports. mdio_phy_o carries that port's address from port_phy_i.
- R12: A sweep started by start_i first clears all stored link bits, so every present, eligible port with link up is written with its link-up bytes.
- R13: A port's two switch writes fall in consecutive cycles, with no MDIO request in between, and both come before any request for the next port. A request holds its address steady until mdio_ack_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Clear stored link states and start a sweep |
| tick_i | input | 1 | Start a sweep that keeps the stored link states |
| port_used_i | input | NPORT | Port is present |
| port_bypass_i | input | NPORT | Port has a fixed configuration handled elsewhere |
| port_phy_i | input | NPORT*PHY_W | PHY address of each port, port 0 in the low bits |
| mdio_req_o | output | 1 | Register read request, held until acknowledged |
| mdio_ext_o | output | 1 | Request is for the external management bus |
| mdio_phy_o | output | PHY_W | PHY address of the request |
| mdio_reg_o | output | 5 | PHY register address of the request |
| mdio_ack_i | input | 1 | Read done; mdio_rdata_i valid this cycle |
| mdio_rdata_i | input | 16 | Read data |
| sw_wr_o | output | 1 | Switch byte write strobe |
| sw_sel_o | output | 1 | 0 = override byte, 1 = traffic-control byte |
| sw_port_o | output | PORT_W | Port being written |
| sw_data_o | output | 8 | Byte written |
| busy_o | output | 1 | Sweep in progress |
| link_state_o | output | NPORT | Stored link state per port |

## Verification
The checker watches protocol and encoding rules on every cycle. It confirms that a request stays steady until it is acknowledged, and that requests go only to eligible ports. It confirms that each override write is followed at once by the matching traffic-control byte, that no request overlaps a write, that override bytes keep their reserved bits clear, and that stored link bits stay still while idle. Speed and duplex resolution, the double status read, the no-PHY value, edge-only reporting and the clearing effect of start can be shown only by the bench. The bench does this with a scripted PHY whose register contents change between sweeps, and compares every write against its own model.

// File: rtl/lres_pkg.sv
// Package: shared constants and types for the PHY link monitor.
// Assumes standard clause-22 PHY register layout for status/ability words.
package lres_pkg;

    // PHY register addresses read by the sweep
    localparam logic [4:0] PHY_REG_STATUS  = 5'd1;
    localparam logic [4:0] PHY_REG_ADV     = 5'd4;
    localparam logic [4:0] PHY_REG_PARTNER = 5'd5;
    localparam logic [4:0] PHY_REG_GCTL    = 5'd9;
    localparam logic [4:0] PHY_REG_GSTAT   = 5'd10;

    // Bit positions inside PHY words
    localparam int STS_LINK = 2;
    localparam int STS_EXT  = 8;
    localparam int ABIL_LO  = 5;   // 4 ability bits: 10H,10F,100H,100F
    localparam int GLOC_LO  = 8;   // local gigabit: half, full
    localparam int GPAR_LO  = 10;  // partner gigabit: half, full

    localparam logic [15:0] NO_PHY = 16'hFFFF;

    // Override byte bit positions
    localparam int OV_LINK = 0;
    localparam int OV_FDX  = 1;
    localparam int OV_100  = 2;
    localparam int OV_1000 = 3;
    localparam int OV_EN   = 6;

    localparam logic [7:0] OVR_DOWN = 8'h40;
    localparam logic [7:0] TC_OFF   = 8'h03;
    localparam logic [7:0] TC_ON    = 8'h00;

    // Sweep sequencer states
    typedef enum logic [3:0] {
        S_IDLE, S_PICK, S_STS1, S_STS2, S_ADV, S_PARTNER,
        S_GCTL, S_GSTAT, S_WOVR, S_WTC, S_NEXT
    } sweep_state_e;

endpackage

// File: rtl/lres_resolve.sv
// Module: lres_resolve
// Turns the masked ability bits of a link-up port into the override byte.
// Assumes gig inputs are zero when no gigabit registers were read.
module lres_resolve
    import lres_pkg::*;
(
    input  logic [3:0] adv_i,    // local 10/100 ability {100F,100H,10F,10H}
    input  logic [3:0] lpa_i,    // partner 10/100 ability, same order
    input  logic [1:0] gloc_i,   // local gigabit {full, half}
    input  logic [1:0] gpar_i,   // partner gigabit {full, half}
    output logic [7:0] ovr_o
);

    logic [3:0] common;
    logic       is100, fdx_base, gig, fdx;

    // Purpose: pick highest common mode and assemble the override byte
    always_comb begin
        common   = adv_i & lpa_i;
        is100    = common[3] | common[2];
        fdx_base = common[3] | (~common[2] & common[1]);
        gig      = (|gloc_i) & (|gpar_i);
        fdx      = gig ? gpar_i[1] : fdx_base;
        ovr_o          = '0;
        ovr_o[OV_EN]   = 1'b1;
        ovr_o[OV_LINK] = 1'b1;
        ovr_o[OV_1000] = gig;
        ovr_o[OV_100]  = ~gig & is100;
        ovr_o[OV_FDX]  = fdx;
    end

endmodule

// File: rtl/lres_link_store.sv
// Module: lres_link_store
// Holds one remembered link bit per port; cleared by reset or clear strobe.
// Assumes at most one port updated per cycle.
module lres_link_store #(
    parameter int NPORT  = 8,
    parameter int PORT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              upd_i,
    input  logic [PORT_W-1:0] upd_idx_i,
    input  logic              upd_val_i,
    output logic [NPORT-1:0]  state_o
);

    for (genvar i = 0; i < NPORT; i++) begin : g_bit
        // Purpose: keep port i's last reported link level
        always_ff @(posedge clk) begin
            if (!rst_n)
                state_o[i] <= 1'b0;
            else if (clr_i)
                state_o[i] <= 1'b0;
            else if (upd_i && upd_idx_i == PORT_W'(i))
                state_o[i] <= upd_val_i;
        end
    end

endmodule

// File: rtl/lres_port_cfg.sv
// Module: lres_port_cfg
// Looks up eligibility, bus side and PHY address for the current port.
// Assumes port_idx_i < NPORT.
module lres_port_cfg #(
    parameter int NPORT     = 8,
    parameter int PORT_W    = 3,
    parameter int PHY_W     = 5,
    parameter int EXT_FIRST = 4
) (
    input  logic [PORT_W-1:0]      port_idx_i,
    input  logic [NPORT-1:0]       used_i,
    input  logic [NPORT-1:0]       bypass_i,
    input  logic [NPORT*PHY_W-1:0] phy_i,
    output logic                   eligible_o,
    output logic                   ext_o,
    output logic [PHY_W-1:0]       phy_o
);

    logic [NPORT-1:0] ext_mask;

    for (genvar i = 0; i < NPORT; i++) begin : g_ext
        assign ext_mask[i] = (i >= EXT_FIRST);
    end

    // Purpose: select per-port attributes for the port under service
    always_comb begin
        eligible_o = used_i[port_idx_i] & ~bypass_i[port_idx_i];
        ext_o      = ext_mask[port_idx_i];
        phy_o      = phy_i[port_idx_i*PHY_W +: PHY_W];
    end

endmodule

// File: rtl/lres_link_monitor.sv
// Module: lres_link_monitor (top)
// Sweeps ports, polls PHY registers, resolves link, writes switch bytes on
// link edges. Assumes the MDIO side acknowledges every request eventually
// and that switch byte writes are accepted in the cycle they are strobed.
module lres_link_monitor
    import lres_pkg::*;
#(
    parameter int NPORT     = 8,
    parameter int PHY_W     = 5,
    parameter int EXT_FIRST = 4,
    localparam int PORT_W   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   tick_i,
    input  logic [NPORT-1:0]       port_used_i,
    input  logic [NPORT-1:0]       port_bypass_i,
    input  logic [NPORT*PHY_W-1:0] port_phy_i,
    output logic                   mdio_req_o,
    output logic                   mdio_ext_o,
    output logic [PHY_W-1:0]       mdio_phy_o,
    output logic [4:0]             mdio_reg_o,
    input  logic                   mdio_ack_i,
    input  logic [15:0]            mdio_rdata_i,
    output logic                   sw_wr_o,
    output logic                   sw_sel_o,
    output logic [PORT_W-1:0]      sw_port_o,
    output logic [7:0]             sw_data_o,
    output logic                   busy_o,
    output logic [NPORT-1:0]       link_state_o
);

    sweep_state_e      st_q, st_d;
    logic [PORT_W-1:0] port_q, port_d;
    logic              down_q, ext_sts_q;
    logic [3:0]        adv_q, lpa_q;
    logic [1:0]        gloc_q, gpar_q;
    logic              eligible, accept, clr, sts_new, upd;
    logic [7:0]        ovr_up;

    lres_port_cfg #(
        .NPORT(NPORT), .PORT_W(PORT_W), .PHY_W(PHY_W), .EXT_FIRST(EXT_FIRST)
    ) u_cfg (
        .port_idx_i (port_q),
        .used_i     (port_used_i),
        .bypass_i   (port_bypass_i),
        .phy_i      (port_phy_i),
        .eligible_o (eligible),
        .ext_o      (mdio_ext_o),
        .phy_o      (mdio_phy_o)
    );

    lres_link_store #(.NPORT(NPORT), .PORT_W(PORT_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr),
        .upd_i     (upd),
        .upd_idx_i (port_q),
        .upd_val_i (mdio_rdata_i[STS_LINK]),
        .state_o   (link_state_o)
    );

    lres_resolve u_res (
        .adv_i  (adv_q),
        .lpa_i  (lpa_q),
        .gloc_i (gloc_q),
        .gpar_i (gpar_q),
        .ovr_o  (ovr_up)
    );

    // Purpose: decode sweep launch, store clear and link-edge strobe
    always_comb begin
        accept  = (st_q == S_IDLE) && (start_i || tick_i);
        clr     = (st_q == S_IDLE) && start_i;
        sts_new = (mdio_rdata_i != NO_PHY) &&
                  (mdio_rdata_i[STS_LINK] != link_state_o[port_q]);
        upd     = (st_q == S_STS2) && mdio_ack_i && sts_new;
    end

    // Purpose: next-state and next-port logic of the sweep sequencer
    always_comb begin
        st_d   = st_q;
        port_d = port_q;
        case (st_q)
            S_IDLE:    if (accept) begin st_d = S_PICK; port_d = '0; end
            S_PICK:    st_d = eligible ? S_STS1 : S_NEXT;
            S_STS1:    if (mdio_ack_i) st_d = S_STS2;
            S_STS2:    if (mdio_ack_i) begin
                           if (!sts_new)                     st_d = S_NEXT;
                           else if (mdio_rdata_i[STS_LINK])  st_d = S_ADV;
                           else                              st_d = S_WOVR;
                       end
            S_ADV:     if (mdio_ack_i) st_d = S_PARTNER;
            S_PARTNER: if (mdio_ack_i) st_d = ext_sts_q ? S_GCTL : S_WOVR;
            S_GCTL:    if (mdio_ack_i) st_d = S_GSTAT;
            S_GSTAT:   if (mdio_ack_i) st_d = S_WOVR;
            S_WOVR:    st_d = S_WTC;
            S_WTC:     st_d = S_NEXT;
            S_NEXT:    if (port_q == PORT_W'(NPORT - 1)) st_d = S_IDLE;
                       else begin st_d = S_PICK; port_d = port_q + 1'b1; end
            default:   st_d = S_IDLE;
        endcase
    end

    // Purpose: sequencer state and port index registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            port_q <= '0;
        end else begin
            st_q   <= st_d;
            port_q <= port_d;
        end
    end

    // Purpose: capture the PHY fields needed for resolution
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            down_q    <= 1'b0;
            ext_sts_q <= 1'b0;
            adv_q     <= '0;
            lpa_q     <= '0;
            gloc_q    <= '0;
            gpar_q    <= '0;
        end else if (mdio_ack_i) begin
            case (st_q)
                S_STS2: begin
                    down_q    <= ~mdio_rdata_i[STS_LINK];
                    ext_sts_q <= mdio_rdata_i[STS_EXT];
                    gloc_q    <= '0;
                    gpar_q    <= '0;
                end
                S_ADV:     adv_q  <= mdio_rdata_i[ABIL_LO +: 4];
                S_PARTNER: lpa_q  <= mdio_rdata_i[ABIL_LO +: 4];
                S_GCTL:    gloc_q <= mdio_rdata_i[GLOC_LO +: 2];
                S_GSTAT:   gpar_q <= mdio_rdata_i[GPAR_LO +: 2];
                default: ;
            endcase
        end
    end

    // Purpose: drive MDIO request address from the sequencer state
    always_comb begin
        mdio_req_o = 1'b1;
        case (st_q)
            S_STS1, S_STS2: mdio_reg_o = PHY_REG_STATUS;
            S_ADV:          mdio_reg_o = PHY_REG_ADV;
            S_PARTNER:      mdio_reg_o = PHY_REG_PARTNER;
            S_GCTL:         mdio_reg_o = PHY_REG_GCTL;
            S_GSTAT:        mdio_reg_o = PHY_REG_GSTAT;
            default: begin
                mdio_req_o = 1'b0;
                mdio_reg_o = '0;
            end
        endcase
    end

    // Purpose: drive switch byte writes and the busy flag
    always_comb begin
        sw_wr_o   = (st_q == S_WOVR) || (st_q == S_WTC);
        sw_sel_o  = (st_q == S_WTC);
        sw_port_o = port_q;
        if (st_q == S_WTC)
            sw_data_o = down_q ? TC_OFF : TC_ON;
        else if (st_q == S_WOVR)
            sw_data_o = down_q ? OVR_DOWN : ovr_up;
        else
            sw_data_o = '0;
        busy_o = (st_q != S_IDLE);
    end

endmodule

// File: rtl/lres_link_monitor_chk.sv
// Module: lres_link_monitor_chk
// Protocol and encoding checks for lres_link_monitor, attached by bind.
module lres_link_monitor_chk #(
    parameter int NPORT  = 8,
    parameter int PORT_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              mdio_req_o,
    input logic              mdio_ack_i,
    input logic [4:0]        mdio_reg_o,
    input logic              sw_wr_o,
    input logic              sw_sel_o,
    input logic [7:0]        sw_data_o,
    input logic [NPORT-1:0]  link_state_o,
    input logic [NPORT-1:0]  port_used_i,
    input logic [NPORT-1:0]  port_bypass_i,
    input logic [PORT_W-1:0] port_q
);

    // R13: an unacknowledged request keeps its register address
    a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req_o && !mdio_ack_i) |=> (mdio_req_o && $stable(mdio_reg_o)));

    // R13: no MDIO request while a switch byte is written
    a_r13_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_o |-> !mdio_req_o);

    // R3: requests are only issued for eligible ports
    a_r3_eligible_only: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_req_o |-> (port_used_i[port_q] && !port_bypass_i[port_q]));

    // R7: link-down override is followed by traffic off
    a_r7_down_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_o && !sw_sel_o && sw_data_o == 8'h40)
        |=> (sw_wr_o && sw_sel_o && sw_data_o == 8'h03));

    // R10: link-up override is followed by traffic on
    a_r10_up_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_o && !sw_sel_o && sw_data_o[0])
        |=> (sw_wr_o && sw_sel_o && sw_data_o == 8'h00));

    // R10: override bytes carry enable, clear reserved bits, one speed bit
    a_r10_ovr_form: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_o && !sw_sel_o) |-> (sw_data_o[6] && sw_data_o[7] == 1'b0 &&
        sw_data_o[5:4] == 2'b00 && $countones(sw_data_o[3:2]) <= 1));

    // R6: stored link bits do not move while idle unless start clears them
    a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(link_state_o));

endmodule

bind lres_link_monitor lres_link_monitor_chk #(
    .NPORT(NPORT), .PORT_W(PORT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .mdio_req_o   (mdio_req_o),
    .mdio_ack_i   (mdio_ack_i),
    .mdio_reg_o   (mdio_reg_o),
    .sw_wr_o      (sw_wr_o),
    .sw_sel_o     (sw_sel_o),
    .sw_data_o    (sw_data_o),
    .link_state_o (link_state_o),
    .port_used_i  (port_used_i),
    .port_bypass_i(port_bypass_i),
    .port_q       (port_q)
);

// File: tb/tb_lres_link_monitor.sv
module tb_lres_link_monitor;

    localparam int NP = 8;
    localparam int PW = 5;
    localparam int XW = 3;

    logic          clk = 1'b0;
    logic          rst_n, start_i, tick_i;
    logic [NP-1:0] used_v, byp_v;
    logic [NP*PW-1:0] phy_v;
    logic          mdio_req_o, mdio_ext_o;
    logic [PW-1:0] mdio_phy_o;
    logic [4:0]    mdio_reg_o;
    logic          mdio_ack_i;
    logic [15:0]   mdio_rdata_i;
    logic          sw_wr_o, sw_sel_o;
    logic [XW-1:0] sw_port_o;
    logic [7:0]    sw_data_o;
    logic          busy_o;
    logic [NP-1:0] link_state_o;

    always #4 clk = ~clk;

    lres_link_monitor dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_i),
        .port_used_i(used_v), .port_bypass_i(byp_v), .port_phy_i(phy_v),
        .mdio_req_o(mdio_req_o), .mdio_ext_o(mdio_ext_o),
        .mdio_phy_o(mdio_phy_o), .mdio_reg_o(mdio_reg_o),
        .mdio_ack_i(mdio_ack_i), .mdio_rdata_i(mdio_rdata_i),
        .sw_wr_o(sw_wr_o), .sw_sel_o(sw_sel_o), .sw_port_o(sw_port_o),
        .sw_data_o(sw_data_o), .busy_o(busy_o), .link_state_o(link_state_o)
    );

    // Scripted PHY contents and bench model state
    logic [15:0] sts_first[NP], sts_sec[NP], adv[NP], lpa[NP], gctl[NP], gstat[NP];
    int          sts_reads[NP];
    logic [NP-1:0] mirror;
    int          exp_q[$];
    string       tag_q[$];
    int          total = 0, bad = 0;
    int          lat = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural override value from the requirement text (R8, R9, R10)
    function automatic int model_ovr(input int p);
        int com, speed, full;
        com   = (adv[p] & lpa[p]) >> 5;
        speed = 10;
        full  = 0;
        if (com >= 8)      begin speed = 100; full = 1; end
        else if (com >= 4) begin speed = 100; full = 0; end
        else if (com >= 2) full = 1;
        if (sts_sec[p][8] && (gctl[p] & 16'h0300) != 0 && (gstat[p] & 16'h0C00) != 0) begin
            speed = 1000;
            full  = gstat[p][11];
        end
        return 64 + 1 + (speed == 1000 ? 8 : 0) + (speed == 100 ? 4 : 0) + (full ? 2 : 0);
    endfunction

    // PHY responder: acknowledges every request after a short delay
    always @(negedge clk) begin
        if (!rst_n) begin
            mdio_ack_i = 1'b0;
            lat = 0;
        end else if (mdio_ack_i) begin
            mdio_ack_i = 1'b0;
        end else if (mdio_req_o) begin
            if (lat == 2) begin
                int p;
                p = int'(mdio_phy_o) - 8;
                lat = 0;
                if (p < 0 || p >= NP) begin
                    chk(0, "R11", "phy address out of range", int'(mdio_phy_o), 8);
                    p = 0;
                end
                chk(mdio_ext_o == (p >= 4), "R11", "external bus flag",
                    int'(mdio_ext_o), int'(p >= 4));
                chk(used_v[p] && !byp_v[p], "R3", "request for ineligible port", p, -1);
                case (mdio_reg_o)
                    5'd1: begin
                        mdio_rdata_i = (sts_reads[p] % 2 == 0) ? sts_first[p] : sts_sec[p];
                        sts_reads[p]++;
                    end
                    5'd4:  mdio_rdata_i = adv[p];
                    5'd5:  mdio_rdata_i = lpa[p];
                    5'd9:  mdio_rdata_i = gctl[p];
                    5'd10: mdio_rdata_i = gstat[p];
                    default: begin
                        mdio_rdata_i = 16'h0;
                        chk(0, "R9", "unexpected register", int'(mdio_reg_o), 1);
                    end
                endcase
                mdio_ack_i = 1'b1;
            end else begin
                lat++;
            end
        end
    end

    // Write monitor: every switch write is compared with the model queue
    always @(negedge clk) begin
        if (rst_n && sw_wr_o) begin
            int act;
            act = int'(sw_port_o) * 512 + int'(sw_sel_o) * 256 + int'(sw_data_o);
            chk(!mdio_req_o, "R13", "request during write", 1, 0);
            if (exp_q.size() == 0) begin
                chk(0, "R6", "unexpected switch write", act, -1);
            end else begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(act == e, t, "switch write {port,sel,data}", act, e);
            end
        end
    end

    task automatic push_port(input int p, input string force_tag);
        string t;
        int ov, tc;
        if (sts_sec[p][2]) begin
            ov = model_ovr(p);
            tc = 0;
            if (force_tag != "")              t = force_tag;
            else if (sts_first[p] != sts_sec[p]) t = "R4";
            else if (ov[3])                   t = "R9";
            else                              t = "R8";
        end else begin
            ov = 8'h40;
            tc = 8'h03;
            t  = "R7";
        end
        exp_q.push_back(p * 512 + ov);
        tag_q.push_back(t);
        exp_q.push_back(p * 512 + 256 + tc);
        tag_q.push_back(sts_sec[p][2] ? "R10" : "R7");
        mirror[p] = sts_sec[p][2];
    endtask

    task automatic sweep(input bit use_start, input bit extra_tick, input string force_tag);
        if (use_start) mirror = '0;
        for (int p = 0; p < NP; p++) begin
            if (used_v[p] && !byp_v[p] && sts_sec[p] != 16'hFFFF && sts_sec[p][2] != mirror[p])
                push_port(p, force_tag);
        end
        if (use_start) start_i = 1'b1; else tick_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        tick_i  = 1'b0;
        chk(busy_o, "R2", "busy after launch", int'(busy_o), 1);
        if (extra_tick) begin
            repeat (3) @(negedge clk);
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
        chk(exp_q.size() == 0, use_start ? "R12" : "R6", "writes missing", exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
        chk(link_state_o == mirror, use_start ? "R12" : "R6", "stored link states",
            int'(link_state_o), int'(mirror));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "WD", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; tick_i = 1'b0;
        mdio_ack_i = 1'b0; mdio_rdata_i = 16'h0; mirror = '0;
        for (int p = 0; p < NP; p++) begin
            phy_v[p*PW +: PW] = PW'(8 + p);
            sts_reads[p] = 0;
            gctl[p] = 16'h0; gstat[p] = 16'h0;
            adv[p] = 16'h01E1; lpa[p] = 16'h01E1;
        end
        used_v = 8'b1111_0111;
        byp_v  = 8'b0010_0000;
        // p0 latched-low first read, up 100 full
        sts_first[0] = 16'h0000; sts_sec[0] = 16'h0004;
        // p1 up, only 10 half in common
        sts_first[1] = 16'h0004; sts_sec[1] = 16'h0004; adv[1] = 16'h0061; lpa[1] = 16'h0021;
        // p2 down
        sts_first[2] = 16'h0000; sts_sec[2] = 16'h0000;
        // p3 unused but up
        sts_first[3] = 16'h0004; sts_sec[3] = 16'h0004;
        // p4 gigabit full
        sts_first[4] = 16'h0104; sts_sec[4] = 16'h0104; gctl[4] = 16'h0300; gstat[4] = 16'h0C00;
        // p5 bypass, up
        sts_first[5] = 16'h0004; sts_sec[5] = 16'h0004;
        // p6 no PHY
        sts_first[6] = 16'hFFFF; sts_sec[6] = 16'hFFFF;
        // p7 extended, partner without gigabit, 100 half common
        sts_first[7] = 16'h0104; sts_sec[7] = 16'h0104; lpa[7] = 16'h00A1; gctl[7] = 16'h0300;

        repeat (5) @(negedge clk);
        chk(!busy_o, "R1", "busy in reset", int'(busy_o), 0);
        chk(!mdio_req_o, "R1", "request in reset", int'(mdio_req_o), 0);
        chk(!sw_wr_o, "R1", "write in reset", int'(sw_wr_o), 0);
        chk(link_state_o == '0, "R1", "link states in reset", int'(link_state_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // First sweep from start: reports all present up ports
        sweep(1'b1, 1'b0, "");
        chk(!link_state_o[6], "R5", "no-PHY port state", int'(link_state_o[6]), 0);
        chk(!link_state_o[3] && !link_state_o[5], "R3", "skipped port states",
            int'(link_state_o), int'(mirror));

        // Nothing changed: a tick sweep writes nothing
        sweep(1'b0, 1'b0, "");

        // p0 and p1 go down, p2 up at gigabit half; extra tick mid-sweep
        sts_first[0] = 16'h0000; sts_sec[0] = 16'h0000;
        sts_first[1] = 16'h0000; sts_sec[1] = 16'h0000;
        sts_first[2] = 16'h0104; sts_sec[2] = 16'h0104;
        adv[2] = 16'h0041; lpa[2] = 16'h0041; gctl[2] = 16'h0200; gstat[2] = 16'h0400;
        sweep(1'b0, 1'b1, "");
        begin
            bit stayed;
            stayed = 1'b1;
            repeat (20) begin
                @(negedge clk);
                if (busy_o) stayed = 1'b0;
            end
            chk(stayed, "R2", "tick during sweep ignored", int'(!stayed), 0);
        end

        // p7 goes down
        sts_first[7] = 16'h0000; sts_sec[7] = 16'h0000;
        sweep(1'b0, 1'b0, "");

        // p7 up without extended status: gigabit registers must be skipped
        sts_first[7] = 16'h0004; sts_sec[7] = 16'h0004;
        adv[7] = 16'h0041; lpa[7] = 16'h0061; gctl[7] = 16'h0300; gstat[7] = 16'h0C00;
        sweep(1'b0, 1'b0, "");
        chk(link_state_o[7], "R9", "p7 up without gigabit", int'(link_state_o[7]), 1);

        // Start clears stored states: every up port is written again
        sweep(1'b1, 1'b0, "R12");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule